// File: doc/BRIEF.md
# Pair-coded GPIO bank register

This block is one 32-bit register that controls a small bank of general-purpose pins, up to eight. Every pin owns two command pairs in the written word. A pair in the low half moves the output latch low or high. A pair in the high half turns the output driver on or off. Each command bit acts only when it is written as one. A writer can therefore change a single attribute of a single pin with a one-hot word, and it needs no read-modify-write cycle. Two agents that share the register cannot overwrite each other's pins.

The value read back is a status view and not a copy of the last write. For each pin it shows the direction, and it shows either the output latch or the synchronised input level, depending on that direction. Software toggles an output by reading its latch bit and then issuing the opposite command. Each pin is a two-state machine with states PIN_IN (driver off) and PIN_OUT (driver on). The transition GO_OUT is taken on an enable-only command, and the transition GO_IN on a disable-only command. Any other write, including one that asserts both bits of the pair, keeps the state. Pin inputs pass through a two-flop synchroniser before they reach the readback.

Top module: `gpx_pair_bank`

## Requirements
- R1: After reset every pin is in PIN_IN with its output latch low: `pin_oe` = 0, `pin_out` = 0, and `rd_data` = 0 while the pin inputs are low.
- R2: A write with bit 2n+1 = 1 and bit 2n = 0 sets `pin_out[n]` to 1 from the next clock. A write with bit 2n = 1 and bit 2n+1 = 0 sets it to 0. The latch can be written in either direction state.
- R3: A write with bit 16+2n = 1 and bit 17+2n = 0 moves pin n to PIN_OUT (`pin_oe[n]` = 1) from the next clock. Bit 17+2n = 1 with bit 16+2n = 0 moves it to PIN_IN (`pin_oe[n]` = 0).
- R4: A write bit that is 0 has no effect. A one-hot command word changes only the attribute of the one pin it names, and an all-zero write changes nothing.
- R5: A write that asserts both bits of one pair leaves that pin's attribute unchanged.
- R6: For a pin in PIN_OUT, read bit 2n equals the output latch, bit 16+2n reads 1, and bit 2n+1 reads 0. Bit 17+2n reads 0 in every state.
- R7: For a pin in PIN_IN, read bit 2n+1 equals the synchronised input level (1 = high), and bits 2n and 16+2n read 0.
- R8: A change on `pin_in[n]` reaches read bit 2n+1 after exactly two rising clock edges.
- R9: When NPINS < 8, command bits of pins at index NPINS and above are ignored, and their four read bits read 0.
- R10: While `wr_en` is 0, `wr_data` has no effect on any pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one clock per command word |
| wr_data | input | 32 | Command word of level and direction pairs |
| rd_data | output | 32 | Status view of direction, latch and input |
| pin_in | input | NPINS | Raw pin levels, asynchronous |
| pin_out | output | NPINS | Output latches |
| pin_oe | output | NPINS | Output driver enables |

## Verification
On every cycle the assertions check the single-clock effect of set, clear, enable and disable commands, the hold on idle and both-bit writes, and the readback encoding for each direction. They also check the two-edge input delay and the zero readback of absent pins. Only the bench scenarios show that a one-hot write leaves every other pin intact across a sequence of writes, that the latch written while a pin is an input is the level the pin drives once it is enabled, and that a narrow instance ignores commands aimed at missing pins.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int REG_W  = 32;
    localparam int HALF_W = REG_W / 2;
    localparam int MAX_PINS = HALF_W / 2;

    typedef enum logic {
        PIN_IN  = 1'b0,
        PIN_OUT = 1'b1
    } pin_dir_e;
endpackage

// File: rtl/gpx_sync2.sv
module gpx_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/gpx_pin_cell.sv
module gpx_pin_cell
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       lvl_clr,
    input  logic       lvl_set,
    input  logic       dir_on,
    input  logic       dir_off,
    input  logic       in_sync,
    output logic       level,
    output logic       drive_en,
    output logic [1:0] rd_lvl_pair,
    output logic [1:0] rd_dir_pair
);
    pin_dir_e state_q, state_d;
    logic     level_d;

    // direction state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IN:  if (cmd_valid && dir_on && !dir_off) state_d = PIN_OUT; // GO_OUT
            PIN_OUT: if (cmd_valid && dir_off && !dir_on) state_d = PIN_IN;  // GO_IN
            default: state_d = PIN_IN;
        endcase
    end

    always_comb begin
        level_d = level;
        if (cmd_valid && lvl_set && !lvl_clr)
            level_d = 1'b1;
        else if (cmd_valid && lvl_clr && !lvl_set)
            level_d = 1'b0;
    end

    // state register and latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_IN;
            level   <= 1'b0;
        end else begin
            state_q <= state_d;
            level   <= level_d;
        end
    end

    // outputs
    always_comb begin
        drive_en    = 1'b0;
        rd_lvl_pair = 2'b00;
        rd_dir_pair = 2'b00;
        unique case (state_q)
            PIN_IN: begin
                rd_lvl_pair = {in_sync, 1'b0};
            end
            PIN_OUT: begin
                drive_en    = 1'b1;
                rd_lvl_pair = {1'b0, level};
                rd_dir_pair = 2'b01;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gpx_pair_bank.sv
module gpx_pair_bank
    import gpx_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);
    localparam int PAIR = 2;

    logic [NPINS-1:0] in_sync;
    logic [1:0]       lvl_pair [NPINS];
    logic [1:0]       dir_pair [NPINS];

    gpx_sync2 #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (in_sync)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpx_pin_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd_valid   (wr_en),
            .lvl_clr     (wr_data[PAIR*i]),
            .lvl_set     (wr_data[PAIR*i+1]),
            .dir_on      (wr_data[HALF_W+PAIR*i]),
            .dir_off     (wr_data[HALF_W+PAIR*i+1]),
            .in_sync     (in_sync[i]),
            .level       (pin_out[i]),
            .drive_en    (pin_oe[i]),
            .rd_lvl_pair (lvl_pair[i]),
            .rd_dir_pair (dir_pair[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NPINS; i++) begin
            rd_data[PAIR*i +: PAIR]        = lvl_pair[i];
            rd_data[HALF_W+PAIR*i +: PAIR] = dir_pair[i];
        end
    end
endmodule

// File: rtl/gpx_pair_bank_chk.sv
module gpx_pair_bank_chk
    import gpx_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe
);
    logic [1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_cnt <= '0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pin_out) && $stable(pin_oe))); // R10

    for (genvar n = 0; n < MAX_PINS; n++) begin : g_chk
        if (n < NPINS) begin : g_real
            AST_LVL_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data[2*n+1] && !wr_data[2*n]) |=> pin_out[n]); // R2
            AST_LVL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data[2*n] && !wr_data[2*n+1]) |=> !pin_out[n]); // R2
            AST_DIR_ON: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data[16+2*n] && !wr_data[17+2*n]) |=> pin_oe[n]); // R3
            AST_DIR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data[17+2*n] && !wr_data[16+2*n]) |=> !pin_oe[n]); // R3
            AST_LVL_NOCMD: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (wr_data[2*n] == wr_data[2*n+1])) |=> $stable(pin_out[n])); // R5
            AST_DIR_NOCMD: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (wr_data[16+2*n] == wr_data[17+2*n])) |=> $stable(pin_oe[n])); // R4
            AST_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
                pin_oe[n] |-> (rd_data[2*n] == pin_out[n] && !rd_data[2*n+1] && rd_data[16+2*n])); // R6
            AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_data[17+2*n]); // R6
            AST_READ_IN: assert property (@(posedge clk) disable iff (!rst_n)
                !pin_oe[n] |-> (!rd_data[2*n] && !rd_data[16+2*n])); // R7
            AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
                (run_cnt >= 2'd2 && !pin_oe[n]) |-> (rd_data[2*n+1] == $past(pin_in[n], 2))); // R8
        end else begin : g_absent
            AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_data[2*n +: 2] == 2'b00 && rd_data[16+2*n +: 2] == 2'b00)); // R9
        end
    end
endmodule

bind gpx_pair_bank gpx_pair_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/gpx_pair_bank_bench.sv
`timescale 1ns/1ps
module gpx_pair_bank_bench;
    localparam int NARROW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  pin_in = '0;
    logic [31:0] rd_w, rd_n;
    logic [7:0]  po_w, oe_w;
    logic [NARROW-1:0] po_n, oe_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_lvl = '0;
    logic [7:0] m_dir = '0;
    logic [7:0] m_syn = '0;

    typedef struct {
        string       tag;
        logic [31:0] rd8;
        logic [7:0]  po8;
        logic [7:0]  oe8;
        logic [31:0] rd5;
        logic [7:0]  po5;
        logic [7:0]  oe5;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    gpx_pair_bank #(.NPINS(8)) u_gpx_pair_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_w), .pin_in(pin_in), .pin_out(po_w), .pin_oe(oe_w)
    );

    gpx_pair_bank #(.NPINS(NARROW)) u_gpx_pair_bank_narrow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_n), .pin_in(pin_in[NARROW-1:0]), .pin_out(po_n), .pin_oe(oe_n)
    );

    function automatic logic [31:0] model_rd(int np);
        logic [31:0] r = '0;
        for (int n = 0; n < np; n++) begin
            if (m_dir[n]) begin
                r[16+2*n] = 1'b1;
                r[2*n]    = m_lvl[n];
            end else begin
                r[2*n+1]  = m_syn[n];
            end
        end
        return r;
    endfunction

    function automatic void model_apply(logic [31:0] d);
        for (int n = 0; n < 8; n++) begin
            if (d[2*n+1] && !d[2*n]) m_lvl[n] = 1'b1;
            if (d[2*n] && !d[2*n+1]) m_lvl[n] = 1'b0;
            if (d[16+2*n] && !d[17+2*n]) m_dir[n] = 1'b1;
            if (d[17+2*n] && !d[16+2*n]) m_dir[n] = 1'b0;
        end
    endfunction

    task automatic push(string tag);
        exp_t e;
        e.tag = tag;
        e.rd8 = model_rd(8);
        e.po8 = m_lvl;
        e.oe8 = m_dir;
        e.rd5 = model_rd(NARROW);
        e.po5 = {3'b000, m_lvl[NARROW-1:0]};
        e.oe5 = {3'b000, m_dir[NARROW-1:0]};
        q.push_back(e);
    endtask

    task automatic wr(string tag, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        model_apply(d);
        push(tag);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(string tag, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = d;
        @(posedge clk);
        push(tag);
        @(negedge clk);
        wr_data = '0;
    endtask

    task automatic drive_pins(string tag, logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        @(posedge clk);
        push({tag, " stage1"});
        @(posedge clk);
        m_syn = v;
        push(tag);
        @(negedge clk);
    endtask

    // monitor: pops one expected item per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (rd_w !== e.rd8 || po_w !== e.po8 || oe_w !== e.oe8 ||
                    rd_n !== e.rd5 || {3'b000, po_n} !== e.po5 || {3'b000, oe_n} !== e.oe5) begin
                    bad++;
                    $display("FAIL %s: rd=%h/%h out=%h/%h oe=%h/%h exp rd=%h/%h out=%h/%h oe=%h/%h",
                             e.tag, rd_w, rd_n, po_w, po_n, oe_w, oe_n,
                             e.rd8, e.rd5, e.po8, e.po5, e.oe8, e.oe5);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        push("R1 reset state");
        @(negedge clk);

        wr("R3 enable pin0", 32'h0001_0000);
        wr("R2 R6 set pin0", 32'h0000_0002);
        wr("R2 clear pin0 after readback", 32'h0000_0001);
        wr("R2 set pin0 again", 32'h0000_0002);
        wr("R5 both level bits pin0", 32'h0000_0003);
        wr("R5 both dir bits pin0", 32'h0003_0000);
        wr("R4 R2 set pin5 latch while input", 32'h0000_0800);
        wr("R4 zero write", 32'h0000_0000);
        wr("R9 R3 R2 all pins out and high", 32'h5555_AAAA);
        wr("R3 disable pin3 only", 32'h0080_0000);
        wr("R2 clear pin6 only", 32'h0000_1000);
        idle("R10 idle with all bits on bus", 32'hFFFF_FFFF);
        idle("R10 idle with clear pattern", 32'hAAAA_5555);
        wr("R9 R5 all pairs both", 32'hFFFF_FFFF);
        wr("R3 R7 all pins input", 32'hAAAA_0000);
        drive_pins("R8 R7 pin2 high", 8'h04);
        drive_pins("R8 R7 mixed inputs", 8'hA5);
        drive_pins("R8 R9 all inputs high", 8'hFF);
        wr("R6 R7 pin7 out among inputs", 32'h4000_0000);
        wr("R9 commands on high pins", 32'h5500_A000);
        drive_pins("R8 inputs low", 8'h00);

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule